// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block receives frames from one asynchronous serial line that idles high. It resynchronises the line into the local clock domain and treats a high-to-low transition as the origin of a frame. From there it samples every bit at its centre, using a clocks-per-bit value supplied at run time. It assembles 5 to 9 data bits, least or most significant first, optionally checks a parity bit of a selectable kind, and then checks a single stop bit.

The receiver reports faults but never aborts a frame. A start bit that reads high at its centre, a wrong parity bit and a low stop bit each raise a one-cycle flag, and reception carries on through the rest of the frame. The assembled word leaves on a one-cycle valid strobe and stays on its port until the next word arrives. All configuration comes in on ports that are expected to stay steady while a frame is in progress.

Top module: `uart_frame_rx`

## Requirements
- R1: A synchronous active-high reset clears `word_o` to zero, holds all four strobes low, and returns the receiver to waiting for a start edge. This also applies when reset arrives in the middle of a frame.
- R2: While the line stays high, no strobe is raised. A frame begins only on a high-to-low transition of the resynchronised line.
- R3: `word_valid_o`, `start_err_o`, `parity_err_o` and `stop_err_o` are one-cycle pulses, and no two of them are high in the same cycle. `word_o` changes only in the cycle `word_valid_o` is high.
- R4: `cfg_nbits_i` selects the number of data bits. Values 5 to 9 are used as given, values below 5 act as 5, and values above 9 act as 9. Bits of `word_o` at positions at or above the data length read zero.
- R5: With `cfg_msb_first_i`=0, the first data bit received lands in `word_o[0]` and the last one in `word_o[N-1]`.
- R6: With `cfg_msb_first_i`=1, the first data bit received lands in `word_o[N-1]` and the last one in `word_o[0]`.
- R7: `cfg_parity_i` code 1 selects odd parity and code 2 selects even parity. `parity_err_o` pulses when the count of ones over the data bits and the parity bit is even (for odd) or odd (for even).
- R8: `cfg_parity_i` code 3 requires the parity bit to be 0 and code 4 requires it to be 1. Any other parity bit value pulses `parity_err_o`.
- R9: `cfg_parity_i` code 0, and codes 5 to 7, mean that no parity bit is present. The stop bit directly follows the last data bit, and `parity_err_o` never pulses.
- R10: If the start bit reads 1 at its centre, `start_err_o` pulses and the data bits, parity bit and stop bit are still received at their normal positions.
- R11: If the stop bit reads 0 at its centre, `stop_err_o` pulses, the word is still delivered, and the receiver goes back to waiting for a start edge.
- R12: Bit k of a frame is sampled at the frame origin plus `cfg_cpb_i`/2 plus k·`cfg_cpb_i` clocks, where `cfg_cpb_i` is any value of at least 4 set between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line_i | input | 1 | Asynchronous serial line, idles high |
| cfg_cpb_i | input | CPB_W (16) | Clock cycles per bit period |
| cfg_nbits_i | input | NB_W (4) | Data bits per frame (5 to 9) |
| cfg_msb_first_i | input | 1 | 1: most significant bit first; 0: least significant first |
| cfg_parity_i | input | 3 | 0 none, 1 odd, 2 even, 3 forced 0, 4 forced 1, 5-7 none |
| word_o | output | MAX_BITS (9) | Last assembled word, zero-extended |
| word_valid_o | output | 1 | One-cycle strobe when `word_o` is updated |
| start_err_o | output | 1 | One-cycle strobe: start bit read high |
| parity_err_o | output | 1 | One-cycle strobe: parity check failed |
| stop_err_o | output | 1 | One-cycle strobe: stop bit read low |

## Verification
The hardest case to reach from the ports is a start bit that reads high at its centre while the frame still continues. A plain low level never produces it, because the line has to fall to begin the frame at all. The stimulus reaches it by driving a low pulse that lasts a quarter of a bit period and then holding the line high for the rest of the start slot, so a falling edge is detected but the centre sample reads 1. Each parity kind is also pushed into its failing branch by flipping the computed parity bit. Random frames mix bit rates, data lengths, bit orders and the three fault injections.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   localparam int unsigned MIN_DATA_BITS = 5;

   typedef enum logic [2:0] {
      PAR_NONE = 3'd0,
      PAR_ODD  = 3'd1,
      PAR_EVEN = 3'd2,
      PAR_ZERO = 3'd3,
      PAR_ONE  = 3'd4
   } par_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PARITY,
      ST_STOP
   } rx_state_e;

   // Unused codes fall back to "no parity bit".
   function automatic par_mode_e decode_par(input logic [2:0] code);
      case (code)
         3'd1:    return PAR_ODD;
         3'd2:    return PAR_EVEN;
         3'd3:    return PAR_ZERO;
         3'd4:    return PAR_ONE;
         default: return PAR_NONE;
      endcase
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
// Resynchronises the serial line and flags a high-to-low transition.
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic line_i,
   output logic line_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("uart_rx_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], line_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign line_o = chain_q[STAGES-1];
   assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_bit_timer.sv
// Down-counter producing a tick at each bit centre.
module uart_rx_bit_timer #(
   parameter int CPB_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_half_i,
   input  logic             run_i,
   input  logic [CPB_W-1:0] period_i,
   output logic             tick_o
);
   logic [CPB_W-1:0] cnt_q;
   logic [CPB_W-1:0] half_m1;
   logic [CPB_W-1:0] full_m1;

   assign half_m1 = (period_i >> 1) - 1'b1;
   assign full_m1 = period_i - 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load_half_i) begin
         cnt_q <= half_m1;
      end else if (run_i) begin
         if (cnt_q == '0) cnt_q <= full_m1;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign tick_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/uart_rx_shifter.sv
// Data word assembly; length and order are selected at run time.
module uart_rx_shifter #(
   parameter int MAX_BITS = 9,
   parameter int NB_W     = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                clear_i,
   input  logic                shift_i,
   input  logic                bit_i,
   input  logic                msb_first_i,
   input  logic [NB_W-1:0]     nbits_i,
   output logic [MAX_BITS-1:0] word_o,
   output logic [MAX_BITS-1:0] word_nxt_o
);
   logic [MAX_BITS-1:0] word_q;
   logic [NB_W-1:0]     top_pos;

   assign top_pos = nbits_i - 1'b1;

   for (genvar i = 0; i < MAX_BITS; i++) begin : g_bit
      logic from_up;
      logic from_dn;
      if (i == MAX_BITS - 1) begin : g_top
         assign from_up = 1'b0;
      end else begin : g_mid_up
         assign from_up = word_q[i+1];
      end
      if (i == 0) begin : g_bot
         assign from_dn = bit_i;
      end else begin : g_mid_dn
         assign from_dn = word_q[i-1];
      end
      assign word_nxt_o[i] = (NB_W'(i) >= nbits_i) ? 1'b0 :
                             msb_first_i            ? from_dn :
                             (NB_W'(i) == top_pos)  ? bit_i : from_up;
   end

   always_ff @(posedge clk) begin
      if (rst || clear_i) word_q <= '0;
      else if (shift_i)   word_q <= word_nxt_o;
   end

   assign word_o = word_q;
endmodule

// File: rtl/uart_rx_parity.sv
// Parity verdict for the assembled word and the sampled parity bit.
module uart_rx_parity
   import uart_rx_pkg::*;
#(
   parameter int MAX_BITS = 9
) (
   input  par_mode_e           mode_i,
   input  logic [MAX_BITS-1:0] word_i,
   input  logic                pbit_i,
   output logic                bad_o
);
   logic ones_odd;
   assign ones_odd = ^word_i;

   always_comb begin
      case (mode_i)
         PAR_ODD:  bad_o = ~(ones_odd ^ pbit_i);
         PAR_EVEN: bad_o = ones_odd ^ pbit_i;
         PAR_ZERO: bad_o = pbit_i;
         PAR_ONE:  bad_o = ~pbit_i;
         default:  bad_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
   import uart_rx_pkg::*;
#(
   parameter int CPB_W       = 16,
   parameter int MAX_BITS    = 9,
   parameter int NB_W        = $clog2(MAX_BITS + 1),
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                rx_line_i,
   input  logic [CPB_W-1:0]    cfg_cpb_i,
   input  logic [NB_W-1:0]     cfg_nbits_i,
   input  logic                cfg_msb_first_i,
   input  logic [2:0]          cfg_parity_i,
   output logic [MAX_BITS-1:0] word_o,
   output logic                word_valid_o,
   output logic                start_err_o,
   output logic                parity_err_o,
   output logic                stop_err_o
);
   localparam logic [NB_W-1:0] NB_MIN = NB_W'(MIN_DATA_BITS);
   localparam logic [NB_W-1:0] NB_MAX = NB_W'(MAX_BITS);

   if (MAX_BITS < int'(MIN_DATA_BITS) || MAX_BITS > 16) begin : g_bad_bits
      $error("uart_frame_rx: MAX_BITS out of range");
   end
   if (CPB_W < 3) begin : g_bad_cpb
      $error("uart_frame_rx: CPB_W too small");
   end

   rx_state_e           state_q;
   logic [NB_W-1:0]     bit_idx_q;
   logic [NB_W-1:0]     nb_eff;
   par_mode_e           par_mode;
   logic                line_s, fall_s, tick;
   logic                par_bad;
   logic [MAX_BITS-1:0] shf_word, shf_nxt;

   assign nb_eff   = (cfg_nbits_i < NB_MIN) ? NB_MIN :
                     (cfg_nbits_i > NB_MAX) ? NB_MAX : cfg_nbits_i;
   assign par_mode = decode_par(cfg_parity_i);

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .line_i (rx_line_i),
      .line_o (line_s),
      .fall_o (fall_s)
   );

   uart_rx_bit_timer #(.CPB_W(CPB_W)) u_timer (
      .clk         (clk),
      .rst         (rst),
      .load_half_i (state_q == ST_IDLE && fall_s),
      .run_i       (state_q != ST_IDLE),
      .period_i    (cfg_cpb_i),
      .tick_o      (tick)
   );

   uart_rx_shifter #(.MAX_BITS(MAX_BITS), .NB_W(NB_W)) u_shift (
      .clk         (clk),
      .rst         (rst),
      .clear_i     (state_q == ST_IDLE && fall_s),
      .shift_i     (state_q == ST_DATA && tick),
      .bit_i       (line_s),
      .msb_first_i (cfg_msb_first_i),
      .nbits_i     (nb_eff),
      .word_o      (shf_word),
      .word_nxt_o  (shf_nxt)
   );

   uart_rx_parity #(.MAX_BITS(MAX_BITS)) u_par (
      .mode_i (par_mode),
      .word_i (shf_word),
      .pbit_i (line_s),
      .bad_o  (par_bad)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q      <= ST_IDLE;
         bit_idx_q    <= '0;
         word_o       <= '0;
         word_valid_o <= 1'b0;
         start_err_o  <= 1'b0;
         parity_err_o <= 1'b0;
         stop_err_o   <= 1'b0;
      end else begin
         word_valid_o <= 1'b0;
         start_err_o  <= 1'b0;
         parity_err_o <= 1'b0;
         stop_err_o   <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (fall_s) state_q <= ST_START;
            end
            ST_START: begin
               if (tick) begin
                  start_err_o <= line_s;
                  bit_idx_q   <= '0;
                  state_q     <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (tick) begin
                  if (bit_idx_q == nb_eff - 1'b1) begin
                     word_o       <= shf_nxt;
                     word_valid_o <= 1'b1;
                     state_q      <= (par_mode == PAR_NONE) ? ST_STOP : ST_PARITY;
                  end else begin
                     bit_idx_q <= bit_idx_q + 1'b1;
                  end
               end
            end
            ST_PARITY: begin
               if (tick) begin
                  parity_err_o <= par_bad;
                  state_q      <= ST_STOP;
               end
            end
            ST_STOP: begin
               if (tick) begin
                  stop_err_o <= ~line_s;
                  state_q    <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk #(
   parameter int MAX_BITS = 9,
   parameter int NB_W     = 4
) (
   input logic                clk,
   input logic                rst,
   input logic [NB_W-1:0]     cfg_nbits_i,
   input logic [2:0]          cfg_parity_i,
   input logic [MAX_BITS-1:0] word_o,
   input logic                word_valid_o,
   input logic                start_err_o,
   input logic                parity_err_o,
   input logic                stop_err_o
);
   logic [NB_W-1:0] nb_lim;
   assign nb_lim = (cfg_nbits_i < NB_W'(5)) ? NB_W'(5) :
                   (cfg_nbits_i > NB_W'(MAX_BITS)) ? NB_W'(MAX_BITS) : cfg_nbits_i;

   AST_RST_QUIET: assert property (@(posedge clk)
      rst |=> (!word_valid_o && !start_err_o && !parity_err_o && !stop_err_o && word_o == '0)); // R1

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      word_valid_o |=> !word_valid_o); // R3

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      $onehot0({word_valid_o, start_err_o, parity_err_o, stop_err_o})); // R3

   AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
      !word_valid_o |-> $stable(word_o)); // R3

   AST_WORD_FITS: assert property (@(posedge clk) disable iff (rst)
      word_valid_o |-> ((word_o >> nb_lim) == '0)); // R4

   AST_NO_PARERR_WITHOUT_PARITY: assert property (@(posedge clk) disable iff (rst)
      (cfg_parity_i == 3'd0 || cfg_parity_i > 3'd4) |-> !parity_err_o); // R9
endmodule

bind uart_frame_rx uart_frame_rx_chk #(.MAX_BITS(MAX_BITS), .NB_W(NB_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .cfg_nbits_i  (cfg_nbits_i),
   .cfg_parity_i (cfg_parity_i),
   .word_o       (word_o),
   .word_valid_o (word_valid_o),
   .start_err_o  (start_err_o),
   .parity_err_o (parity_err_o),
   .stop_err_o   (stop_err_o)
);

// File: tb/tb_uart_frame_rx.sv
`timescale 1ns/1ps
module tb_uart_frame_rx;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        rx_line_i = 1'b1;
   logic [15:0] cfg_cpb_i = 16'd16;
   logic [3:0]  cfg_nbits_i = 4'd8;
   logic        cfg_msb_first_i = 1'b0;
   logic [2:0]  cfg_parity_i = 3'd0;
   logic [8:0]  word_o;
   logic        word_valid_o, start_err_o, parity_err_o, stop_err_o;

   int n_chk = 0, n_fail = 0;
   int n_val = 0, n_se = 0, n_pe = 0, n_te = 0;
   logic [8:0] cap_word = '0;
   bit done = 0;

   always #2.5 clk = ~clk;

   uart_frame_rx dut (
      .clk (clk), .rst (rst), .rx_line_i (rx_line_i),
      .cfg_cpb_i (cfg_cpb_i), .cfg_nbits_i (cfg_nbits_i),
      .cfg_msb_first_i (cfg_msb_first_i), .cfg_parity_i (cfg_parity_i),
      .word_o (word_o), .word_valid_o (word_valid_o), .start_err_o (start_err_o),
      .parity_err_o (parity_err_o), .stop_err_o (stop_err_o)
   );

   always @(negedge clk) begin
      if (!rst) begin
         if (word_valid_o) begin n_val++; cap_word = word_o; end
         if (start_err_o)  n_se++;
         if (parity_err_o) n_pe++;
         if (stop_err_o)   n_te++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int eff_len(input int n);
      if (n < 5) return 5;
      if (n > 9) return 9;
      return n;
   endfunction

   function automatic logic [8:0] masked(input logic [8:0] d, input int n);
      return d & 9'((1 << n) - 1);
   endfunction

   function automatic logic par_bit(input logic [8:0] d, input int mode);
      case (mode)
         1: return ~(^d);
         2: return ^d;
         3: return 1'b0;
         4: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic hold(input logic v, input int cyc);
      rx_line_i = v;
      repeat (cyc) @(negedge clk);
   endtask

   task automatic clear_mon();
      n_val = 0; n_se = 0; n_pe = 0; n_te = 0;
   endtask

   task automatic frame(input logic [8:0] data, input int ncfg, input bit msb, input int pmode,
                        input int cpb, input bit bad_par, input bit bad_start, input bit bad_stop);
      int n;
      logic [8:0] dm;
      logic pb;
      bit has_par;
      @(negedge clk);
      cfg_cpb_i = 16'(cpb); cfg_nbits_i = 4'(ncfg);
      cfg_msb_first_i = msb; cfg_parity_i = 3'(pmode);
      n = eff_len(ncfg);
      dm = masked(data, n);
      has_par = (pmode >= 1 && pmode <= 4);
      hold(1'b1, 4);
      clear_mon();
      if (bad_start) begin hold(1'b0, cpb / 4); hold(1'b1, cpb - cpb / 4); end
      else hold(1'b0, cpb);
      for (int i = 0; i < n; i++) hold(msb ? dm[n-1-i] : dm[i], cpb);
      if (has_par) begin
         pb = par_bit(dm, pmode) ^ bad_par;
         hold(pb, cpb);
      end
      if (bad_stop) hold(1'b0, cpb);
      hold(1'b1, 3 * cpb);
      chk(n_val == 1, "R3 one word strobe", n_val, 1);
      chk(cap_word == dm, msb ? "R6 msb-first word (R4 length)" : "R5 lsb-first word (R4 length)",
          int'(cap_word), int'(dm));
      chk(n_se == int'(bad_start), "R10 start flag", n_se, int'(bad_start));
      chk(n_pe == int'(bad_par && has_par),
          (pmode == 1 || pmode == 2) ? "R7 parity flag" : (has_par ? "R8 parity flag" : "R9 parity flag"),
          n_pe, int'(bad_par && has_par));
      chk(n_te == int'(bad_stop), "R11 stop flag", n_te, int'(bad_stop));
   endtask

   initial begin
      void'($urandom(32'd7301));
      repeat (4) @(negedge clk);
      chk(word_o == '0 && !word_valid_o && !start_err_o && !parity_err_o && !stop_err_o,
          "R1 reset state", int'(word_o), 0);
      rst = 1'b0;
      clear_mon();
      hold(1'b1, 300);
      chk(n_val + n_se + n_pe + n_te == 0, "R2 idle line quiet", n_val + n_se + n_pe + n_te, 0);

      // Directed corners
      frame(9'h0A5, 8, 0, 0, 16, 0, 0, 0);  // R5
      frame(9'h0A5, 8, 1, 0, 16, 0, 0, 0);  // R6
      frame(9'h15,  5, 0, 1, 12, 0, 0, 0);  // R4 shortest
      frame(9'h1FF, 9, 1, 2, 12, 0, 0, 0);  // R4 longest
      frame(9'h1FF, 15, 0, 0, 10, 0, 0, 0); // R4 clamp high
      frame(9'h1F,  2, 1, 0, 10, 0, 0, 0);  // R4 clamp low
      frame(9'h03C, 8, 0, 1, 16, 1, 0, 0);  // R7 odd fail
      frame(9'h03D, 8, 0, 2, 16, 1, 0, 0);  // R7 even fail
      frame(9'h081, 7, 0, 3, 16, 1, 0, 0);  // R8 forced zero fail
      frame(9'h081, 7, 1, 4, 16, 1, 0, 0);  // R8 forced one fail
      frame(9'h055, 8, 0, 4, 16, 0, 0, 0);  // R8 forced one pass
      frame(9'h0C3, 8, 0, 6, 16, 1, 0, 0);  // R9 unused code acts as none
      frame(9'h066, 8, 0, 1, 20, 0, 1, 0);  // R10 bad start
      frame(9'h099, 8, 1, 2, 20, 0, 0, 1);  // R11 bad stop
      frame(9'h12D, 9, 0, 0, 434, 0, 0, 0); // R12 long period
      frame(9'h00F, 6, 0, 0, 4, 0, 0, 0);   // R12 shortest period

      // R1: reset in mid-frame, then a clean frame
      @(negedge clk);
      hold(1'b0, 40);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(word_o == '0 && !word_valid_o, "R1 mid-frame reset", int'(word_o), 0);
      rst = 1'b0;
      hold(1'b1, 20);
      frame(9'h0B4, 8, 0, 2, 16, 0, 0, 0);

      // Random frames
      for (int k = 0; k < 60; k++) begin
         int n, pm, cpb;
         logic [8:0] d;
         bit bp, bs, bt;
         n   = 5 + int'($urandom % 5);
         pm  = int'($urandom % 5);
         cpb = 4 + int'($urandom % 37);
         d   = 9'($urandom);
         bp  = ($urandom % 4) == 0;
         bs  = ($urandom % 6) == 0 && cpb >= 12;
         bt  = ($urandom % 6) == 0;
         frame(d, n, 1'($urandom), pm, cpb, bp, bs, bt);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R2 actual=%0h expected=%0h", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule